// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block is the address-decode glue for an 8-bit processor with a 16-bit address bus. It looks at the address, the phase-2 clock and the read/write strobe. From them it produces active-low chip selects and output enables for four targets: low RAM, a banked high-RAM window, a banked ROM window, and eight 32-byte I/O device slots that share one 256-byte page.

Two 8-bit bank registers sit inside the block. The processor writes them by storing to two fixed addresses in low memory. Their contents drive the extra high-order address lines of the RAM and ROM windows. The bank values never take part in decoding, so the output enables stay mutually exclusive whatever banks are selected.

Top module: `memmap_decode`

## Requirements
- R1: Addresses 0xC000 to 0xFFFF drive `rom_cs_n` low. On a read, `rom_oe_n` is also low. `rom_bank` supplies the ROM address bits above A13.
- R2: Addresses 0xA000 to 0xBFFF drive `hram_cs_n` low. On a read, `hram_oe_n` is also low. `hram_bank` supplies the RAM address bits above A12.
- R3: Addresses 0x9F00 to 0x9FFF drive exactly one bit of `io_sel_n` low. The bit index is the value of A7..A5, so slot 0 covers 0x9F00 to 0x9F1F and slot 7 covers 0x9FE0 to 0x9FFF.
- R4: Addresses 0x0000 to 0x9EFF drive `lram_cs_n` low. On a read, `lram_oe_n` is also low.
- R5: While `phi2` is low, every chip select, output enable and I/O select is high (inactive).
- R6: A write cycle (`rw_n` = 0) asserts the matching chip select or I/O select and leaves every output enable high.
- R7: During a read, at most one of the following is low: `lram_oe_n`, `hram_oe_n`, `rom_oe_n`, and any bit of `io_sel_n`. This holds for every address and every pair of bank values.
- R8: A write to address 0x0000 loads `data_in` into `hram_bank`. A write to address 0x0001 loads `data_in` into `rom_bank`. Both loads happen on the falling edge of `phi2`. Reads of those addresses and writes to any other address leave both registers unchanged. Reset clears both registers to 0.
- R9: The bank register values have no effect on which select is asserted. Bank 0 is mapped like any other bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| phi2 | input | 1 | Phase-2 bus clock; high during the data phase |
| rst_n | input | 1 | Asynchronous active-low reset of the bank registers |
| addr | input | 16 | CPU address bus |
| rw_n | input | 1 | 1 = read, 0 = write |
| data_in | input | 8 | CPU data bus, used for bank register writes |
| lram_cs_n | output | 1 | Low-RAM chip select |
| lram_oe_n | output | 1 | Low-RAM output enable |
| hram_cs_n | output | 1 | High-RAM window chip select |
| hram_oe_n | output | 1 | High-RAM window output enable |
| rom_cs_n | output | 1 | ROM window chip select |
| rom_oe_n | output | 1 | ROM window output enable |
| io_sel_n | output | 8 | One select per 32-byte I/O slot |
| hram_bank | output | 8 | Extended address lines for the high-RAM window |
| rom_bank | output | 8 | Extended address lines for the ROM window |

## Verification
The hardest situation to reach is a read that lands on a region edge, such as 0x9EFF next to 0x9F00 or 0x9FFF next to 0xA000. It must be checked while the bank registers hold unusual values that were written only one falling edge earlier.

The stimulus walks all 65,536 addresses as reads and compares each one with an address-range model. It then steps through all 256 bank values, writing both registers and reading through each window right after each write. That exposes any bank leakage into the decode and any off-by-one-edge latch timing.

// File: rtl/memmap_decode.sv
`timescale 1ns/1ps
module memmap_decode #(
  parameter logic [15:0] HRAM_BANK_ADDR = 16'h0000,
  parameter logic [15:0] ROM_BANK_ADDR  = 16'h0001,
  parameter int          BANK_W         = 8
) (
  input  logic              phi2,
  input  logic              rst_n,
  input  logic [15:0]       addr,
  input  logic              rw_n,
  input  logic [7:0]        data_in,
  output logic              lram_cs_n,
  output logic              lram_oe_n,
  output logic              hram_cs_n,
  output logic              hram_oe_n,
  output logic              rom_cs_n,
  output logic              rom_oe_n,
  output logic [7:0]        io_sel_n,
  output logic [BANK_W-1:0] hram_bank,
  output logic [BANK_W-1:0] rom_bank
);
  localparam int SLOTS = 8;

  logic in_rom, in_hram, in_io, in_lram, rd;

  assign in_rom  = (addr[15:14] == 2'b11);
  assign in_hram = (addr[15:13] == 3'b101);
  assign in_io   = (addr[15:13] == 3'b100) && (&addr[12:8]);
  assign in_lram = !(in_rom || in_hram || in_io);
  assign rd      = phi2 && rw_n;

  assign lram_cs_n = !(phi2 && in_lram);
  assign lram_oe_n = !(rd && !in_rom && !in_hram && !in_io);
  assign hram_cs_n = !(phi2 && in_hram);
  assign hram_oe_n = !(rd && in_hram);
  assign rom_cs_n  = !(phi2 && in_rom);
  assign rom_oe_n  = !(rd && in_rom);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign io_sel_n[i] = !(phi2 && in_io && (addr[7:5] == 3'(i)));
  end

  always_ff @(negedge phi2 or negedge rst_n) begin
    if (!rst_n) begin
      hram_bank <= '0;
      rom_bank  <= '0;
    end else if (!rw_n) begin
      if (addr == HRAM_BANK_ADDR) hram_bank <= data_in[BANK_W-1:0];
      if (addr == ROM_BANK_ADDR)  rom_bank  <= data_in[BANK_W-1:0];
    end
  end

  AST_OE_EXCLUSIVE: assert property (@(negedge phi2) disable iff (!rst_n)
    $countones({~lram_oe_n, ~hram_oe_n, ~rom_oe_n, ~io_sel_n & {SLOTS{rw_n}}}) <= 1); // R7
  AST_IO_ONEHOT: assert property (@(negedge phi2) disable iff (!rst_n)
    $onehot0(~io_sel_n)); // R3
  AST_IDLE_LOW_PHASE: assert property (@(posedge phi2) disable iff (!rst_n)
    (lram_cs_n && hram_cs_n && rom_cs_n && lram_oe_n && hram_oe_n && rom_oe_n && (&io_sel_n))); // R5
  AST_WRITE_NO_OE: assert property (@(negedge phi2) disable iff (!rst_n)
    !rw_n |-> (lram_oe_n && hram_oe_n && rom_oe_n)); // R6
  AST_HBANK_LOAD: assert property (@(negedge phi2) disable iff (!rst_n)
    (!rw_n && addr == HRAM_BANK_ADDR) |=> (hram_bank == $past(data_in[BANK_W-1:0]))); // R8
  AST_HBANK_HOLD: assert property (@(negedge phi2) disable iff (!rst_n)
    !(!rw_n && addr == HRAM_BANK_ADDR) |=> $stable(hram_bank)); // R8
  AST_RBANK_HOLD: assert property (@(negedge phi2) disable iff (!rst_n)
    !(!rw_n && addr == ROM_BANK_ADDR) |=> $stable(rom_bank)); // R8
endmodule

// File: tb/tb_memmap_decode.sv
`timescale 1ns/1ps
module tb_memmap_decode;
  logic phi2 = 1'b0, rst_n = 1'b0, rw_n = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0] data_in = 8'h00;
  logic lram_cs_n, lram_oe_n, hram_cs_n, hram_oe_n, rom_cs_n, rom_oe_n;
  logic [7:0] io_sel_n, hram_bank, rom_bank;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 phi2 = ~phi2;

  memmap_decode dut (.phi2(phi2), .rst_n(rst_n), .addr(addr), .rw_n(rw_n), .data_in(data_in),
    .lram_cs_n(lram_cs_n), .lram_oe_n(lram_oe_n), .hram_cs_n(hram_cs_n), .hram_oe_n(hram_oe_n),
    .rom_cs_n(rom_cs_n), .rom_oe_n(rom_oe_n), .io_sel_n(io_sel_n),
    .hram_bank(hram_bank), .rom_bank(rom_bank));

  // region codes: 0 low RAM, 1 high RAM, 2 ROM, 8+n I/O slot n
  localparam int NV = 14;
  localparam logic [15:0] VADDR [NV] = '{16'h0000, 16'h9EFF, 16'h9F00, 16'h9F1F, 16'h9F20,
    16'h9F7F, 16'h9FE0, 16'h9FFF, 16'hA000, 16'hBFFF, 16'hC000, 16'hFFFC, 16'h8000, 16'h5A5A};
  localparam logic [3:0] VCODE [NV] = '{4'd0, 4'd0, 4'd8, 4'd8, 4'd9,
    4'd11, 4'd15, 4'd15, 4'd1, 4'd1, 4'd2, 4'd2, 4'd0, 4'd0};

  function automatic logic [3:0] region(input logic [15:0] a);
    if (a >= 16'hC000) return 4'd2;
    if (a >= 16'hA000) return 4'd1;
    if (a >= 16'h9F00) return 4'(8 + a[7:5]);
    return 4'd0;
  endfunction

  // active-high {lram_cs, lram_oe, hram_cs, hram_oe, rom_cs, rom_oe, io[7:0]}
  function automatic logic [13:0] expect_of(input logic [3:0] code, input logic rd);
    logic [13:0] e = '0;
    case (code)
      4'd0: e[13:12] = {1'b1, rd};
      4'd1: e[11:10] = {1'b1, rd};
      4'd2: e[9:8]   = {1'b1, rd};
      default: e[code[2:0]] = 1'b1;
    endcase
    return e;
  endfunction

  function automatic logic [13:0] actual();
    return ~{lram_cs_n, lram_oe_n, hram_cs_n, hram_oe_n, rom_cs_n, rom_oe_n, io_sel_n};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  task automatic bus(input logic [15:0] a, input logic r, input logic [7:0] d);
    @(negedge phi2); #2;
    addr = a; rw_n = r; data_in = d;
    @(posedge phi2); #5;
  endtask

  task automatic settle();
    @(negedge phi2); #2;
    addr = 16'h4000; rw_n = 1'b1;
  endtask

  initial begin
    #(20 * 195000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #45;
    check("R8 reset hram_bank", 16'(hram_bank), 16'h0);
    check("R8 reset rom_bank", 16'(rom_bank), 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      bus(VADDR[i], 1'b1, 8'h00);
      check("R1-4 table read", 16'(actual()), 16'(expect_of(VCODE[i], 1'b1)));
      bus(VADDR[i], 1'b0, 8'h00);
      check("R6 table write", 16'(actual()), 16'(expect_of(VCODE[i], 1'b0)));
      @(negedge phi2); #5;
      check("R5 low phase idle", 16'(actual()), 16'h0);
    end

    // R8: bank writes land on the falling edge
    bus(16'h0000, 1'b0, 8'h3C);
    check("R8 before edge", 16'(hram_bank), 16'h00);
    settle();
    check("R8 hram load", 16'(hram_bank), 16'h3C);
    bus(16'h0001, 1'b0, 8'hA5);
    settle();
    check("R8 rom load", 16'(rom_bank), 16'hA5);
    check("R8 hram untouched", 16'(hram_bank), 16'h3C);
    bus(16'h0000, 1'b1, 8'hFF);
    bus(16'h0002, 1'b0, 8'hFF);
    bus(16'h9F00, 1'b0, 8'hFF);
    settle();
    check("R8 hold hram", 16'(hram_bank), 16'h3C);
    check("R8 hold rom", 16'(rom_bank), 16'hA5);

    // R1 R2 R3 R4 R7: every address as a read
    for (int a = 0; a < 65536; a++) begin
      bus(16'(a), 1'b1, 8'h00);
      check("R7 sweep", 16'(actual()), 16'(expect_of(region(16'(a)), 1'b1)));
    end

    // R9: every bank value, decode unchanged, extended lines follow
    for (int b = 0; b < 256; b++) begin
      bus(16'h0000, 1'b0, 8'(b));
      bus(16'h0001, 1'b0, 8'(255 - b));
      bus(16'hA000 + 16'(b), 1'b1, 8'h00);
      check("R9 hram decode", 16'(actual()), 16'(expect_of(4'd1, 1'b1)));
      check("R2 hram_bank", 16'(hram_bank), 16'(b));
      bus(16'h9EFF, 1'b1, 8'h00);
      check("R9 edge lram", 16'(actual()), 16'(expect_of(4'd0, 1'b1)));
      bus(16'hFF00 + 16'(b), 1'b1, 8'h00);
      check("R1 rom_bank", 16'(rom_bank), 16'(255 - b));
      check("R9 rom decode", 16'(actual()), 16'(expect_of(4'd2, 1'b1)));
    end

    rst_n = 1'b0;
    #3;
    check("R8 async reset", 16'({hram_bank, rom_bank}), 16'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule